// File: doc/BRIEF.md
# Multi-Channel Interrupt Fan-Out Multiplexer

This block collects a vector of level-sensitive, active-high interrupt request lines and offers the whole vector to every one of a configurable number of output channels. Each channel keeps its own mask word, which chooses the requests it passes on. A channel raises its single interrupt line whenever at least one request that it passes on is active. Software reaches each channel through a small synchronous register port. Through that port it can set and read back the mask, and it can read a pending view that shows which requests are active and enabled on that channel.

Request lines come from other clock domains, so they pass through a two-stage synchronizer before masking. The per-channel outputs are registered. The register map gives each channel a 64-byte window. The upper address bits select the channel, and the low six bits select the register inside the window.

Top module: `irq_fanout_mux`

## Requirements
- R1: While reset is asserted, and right after it is released, every mask word reads zero, every channel output is low and the read data port is zero.
- R2: A write to byte offset 0x10 + 0x40·n (channel n, n below the channel count) stores all 32 data bits as that channel's mask. A later read of that address returns the stored word exactly, so single bits can be changed by read-modify-write.
- R3: A read of byte offset 0x20 + 0x40·n returns the synchronized request vector ANDed with channel n's mask. Bit i is 1 only when request i is active and mask bit i is 1.
- R4: A pending bit follows the request level and holds no history. A change on a request input appears in the pending view two clock edges after it is applied, and the pending bit clears as soon as the synchronized level falls.
- R5: Channel n's output is the OR of its 32 pending bits, registered once. A request change therefore reaches the output three clock edges after it is applied.
- R6: Writes to a pending register are ignored. The mask of every channel is unchanged afterwards.
- R7: Reads of any offset other than 0x10 and 0x20, and of any channel index at or above the channel count, return zero. Writes to those addresses change no mask.
- R8: Writing zero to a mask disables every request on that channel, and its output drops. Writing back a saved mask word restores the same pending pattern as before.
- R9: Read data is registered. The word for an address presented with the read strobe appears after the next clock edge. When the strobe is low, the read data port is zero. A read and a write to the same mask in one cycle return the old mask.
- R10: A write to one channel's mask leaves every other channel's mask and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive request lines, active high, asynchronous |
| bus_addr | input | ADDR_W | Byte address: channel index above bit 5, register offset in bits 5:0 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NUM_SRC | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | NUM_SRC | Registered read data, zero when no read |
| irq_o | output | NUM_CH | One interrupt output per channel |

## Verification
The bench drives disjoint, overlapping and alternating-bit mask patterns across several channels. The same request vector then yields a different pending word and output on each channel, which separates correct per-channel masking from shared or swapped mask storage. Requests are raised and dropped to tell level following apart from latching, and each result is sampled on the exact edge count of the synchronizer and output register, so a missing or extra stage shows up. A pseudo-random phase mixes writes to mapped, pending, unmapped and out-of-range addresses with request changes, and a cycle model compares both outputs on every clock.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  // register offsets inside one channel's 64-byte window
  localparam int unsigned WIN_BITS   = 6;
  localparam logic [5:0]  OFS_MASK   = 6'h10;
  localparam logic [5:0]  OFS_PEND   = 6'h20;
  localparam int unsigned MAX_CH     = 8;
endpackage

// File: rtl/irqmux_sync.sv
module irqmux_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irqmux_chan.sv
module irqmux_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_s_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q <= wdata_i;
    end
  end

  assign pend_o = src_s_i & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_o;
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic               bus_re,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic [NUM_CH-1:0]  irq_o
);
  localparam int unsigned CH_W = ADDR_W - WIN_BITS;

  logic [CH_W-1:0]          ch_sel;
  logic [WIN_BITS-1:0]      reg_ofs;
  logic [NUM_SRC-1:0]       src_s;
  logic [NUM_SRC-1:0]       mask_w [NUM_CH];
  logic [NUM_SRC-1:0]       pend_w [NUM_CH];
  logic [NUM_CH*NUM_SRC-1:0] mask_all;
  logic [NUM_CH*NUM_SRC-1:0] pend_all;
  logic [NUM_SRC-1:0]       rd_next;
  logic [NUM_SRC-1:0]       rdata_q;

  assign ch_sel  = bus_addr[ADDR_W-1:WIN_BITS];
  assign reg_ofs = bus_addr[WIN_BITS-1:0];

  irqmux_sync #(.W(NUM_SRC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (src_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    assign wr_hit = bus_we && (reg_ofs == OFS_MASK) && (int'(ch_sel) == c);

    irqmux_chan #(.W(NUM_SRC)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_hit),
      .wdata_i (bus_wdata),
      .src_s_i (src_s),
      .mask_o  (mask_w[c]),
      .pend_o  (pend_w[c]),
      .irq_o   (irq_o[c])
    );

    assign mask_all[c*NUM_SRC +: NUM_SRC] = mask_w[c];
    assign pend_all[c*NUM_SRC +: NUM_SRC] = pend_w[c];
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(ch_sel) == c) begin
        if (reg_ofs == OFS_MASK)      rd_next = mask_w[c];
        else if (reg_ofs == OFS_PEND) rd_next = pend_w[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_next;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irqmux_chk.sv
module irqmux_chk
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 9
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_SRC-1:0]        src_i,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [NUM_SRC-1:0]        bus_wdata,
  input logic                      bus_re,
  input logic [NUM_SRC-1:0]        bus_rdata,
  input logic [NUM_CH-1:0]         irq_o,
  input logic [NUM_SRC-1:0]        src_s,
  input logic [NUM_CH*NUM_SRC-1:0] mask_all,
  input logic [NUM_CH*NUM_SRC-1:0] pend_all
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst)               cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic mask_hit;
  assign mask_hit = bus_we && (bus_addr[WIN_BITS-1:0] == OFS_MASK) &&
                    (int'(bus_addr[ADDR_W-1:WIN_BITS]) < NUM_CH);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && bus_rdata == '0 && mask_all == '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == '0);

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) |-> src_s == $past(src_i, 2));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_hit |=> $stable(mask_all));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_q >= 2'd1) |-> irq_o[c] == $past(|pend_all[c*NUM_SRC +: NUM_SRC]));

    // R2
    mask_store_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_hit && int'(bus_addr[ADDR_W-1:WIN_BITS]) == c) |=>
        mask_all[c*NUM_SRC +: NUM_SRC] == $past(bus_wdata));
  end
endmodule

bind irq_fanout_mux irqmux_chk #(
  .NUM_CH (NUM_CH),
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_i    (src_i),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_re   (bus_re),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .src_s    (src_s),
  .mask_all (mask_all),
  .pend_all (pend_all)
);

// File: tb/tb_irq_fanout_mux.sv
module tb_irq_fanout_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int NSRC = 32;
  localparam int AW   = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic            bus_re = 1'b0;
  logic [NSRC-1:0] bus_rdata;
  logic [NCH-1:0]  irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_fanout_mux #(.NUM_CH(NCH), .NUM_SRC(NSRC), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference: register contents as plain arrays, pipeline as a queue
  logic [31:0] m_mask [8];
  logic [31:0] m_srcq [$];
  logic [31:0] m_rd;
  logic [7:0]  m_irq;

  function automatic logic [31:0] m_pend(int ch);
    return m_srcq[0] & m_mask[ch];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 8; c++) m_mask[c] = '0;
      m_srcq = '{32'h0, 32'h0};
      m_rd   = '0;
      m_irq  = '0;
    end else begin
      int ch;
      int of;
      logic [31:0] rd;
      logic [7:0]  nirq;
      ch = int'(bus_addr) / 64;
      of = int'(bus_addr) % 64;
      rd = '0;
      if (bus_re && ch < NCH) begin
        if (of == 16) rd = m_mask[ch];
        else if (of == 32) rd = m_pend(ch);
      end
      nirq = '0;
      for (int c = 0; c < NCH; c++) nirq[c] = (m_pend(c) != 0);
      if (bus_we && ch < NCH && of == 16) m_mask[ch] = bus_wdata;
      m_rd  = rd;
      m_irq = nirq;
      m_srcq.push_back(src_i);
      void'(m_srcq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_vec++;
      if (irq_o !== m_irq[NCH-1:0]) begin
        n_bad++;
        $display("FAIL R5 irq_o act=%h exp=%h", irq_o, m_irq[NCH-1:0]);
      end
      if (bus_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL R9 rdata act=%h exp=%h", bus_rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int amask(int ch); return 16 + 64*ch; endfunction
  function automatic int apend(int ch); return 32 + 64*ch; endfunction

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] saved;
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk("R1 irq in reset", {26'd0, irq_o}, 32'h0);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    rd(amask(0), v); chk("R1 mask0 after reset", v, 32'h0);

    // R2 mask writes and readback
    wr(amask(0), 32'hFFFF_0000);
    wr(amask(1), 32'h0000_FFFF);
    wr(amask(5), 32'hAAAA_AAAA);
    rd(amask(0), v); chk("R2 mask0", v, 32'hFFFF_0000);
    rd(amask(5), v); chk("R2 mask5", v, 32'hAAAA_AAAA);
    // R10 untouched channel
    rd(amask(2), v); chk("R10 mask2 untouched", v, 32'h0);

    // R4 / R3 / R5 pending and outputs
    src_i = 32'h0001_0001;
    @(negedge clk);
    @(negedge clk);
    chk("R5 no irq before third edge", {26'd0, irq_o}, 32'h0);
    rd(apend(0), v); chk("R3 pend0", v, 32'h0001_0000);
    chk("R5 irq pattern", {26'd0, irq_o}, 32'h0000_0003);
    rd(apend(1), v); chk("R3 pend1", v, 32'h0000_0001);
    rd(apend(5), v); chk("R3 pend5 masked", v, 32'h0);
    src_i = 32'h0;
    repeat (3) @(negedge clk);
    chk("R4 level drop clears irq", {26'd0, irq_o}, 32'h0);
    rd(apend(0), v); chk("R4 pend no latch", v, 32'h0);

    // R6 write to pending register ignored
    wr(apend(0), 32'hFFFF_FFFF);
    rd(amask(0), v); chk("R6 mask0 kept", v, 32'hFFFF_0000);

    // R7 unmapped and out-of-range
    wr(amask(6), 32'h1234_5678);
    rd(amask(6), v); chk("R7 ch6 mask reads zero", v, 32'h0);
    rd(64*1 + 0, v); chk("R7 offset 0 zero", v, 32'h0);
    rd(64*1 + 48, v); chk("R7 offset 0x30 zero", v, 32'h0);
    wr(64*2 + 4, 32'hFFFF_FFFF);
    rd(amask(2), v); chk("R7 stray write ignored", v, 32'h0);

    // R8 disable all then restore
    src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(amask(0), saved);
    wr(amask(0), 32'h0);
    @(negedge clk);
    chk("R8 ch0 irq off", {31'd0, irq_o[0]}, 32'h0);
    rd(apend(0), v); chk("R8 pend0 empty", v, 32'h0);
    chk("R10 ch1 still on", {31'd0, irq_o[1]}, 32'h1);
    wr(amask(0), saved);
    rd(apend(0), v); chk("R8 pend0 restored", v, 32'hFFFF_0000);

    // R9 read-during-write returns old, idle read is zero
    bus_addr = AW'(amask(3)); bus_wdata = 32'hC3C3_C3C3; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R9 old value on collision", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R9 idle zero", bus_rdata, 32'h0);
    rd(amask(3), v); chk("R9 new value later", v, 32'hC3C3_C3C3);

    // mixed pseudo-random phase checked by the cycle model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src_i     = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      bus_addr  = AW'({lfsr[8:6], (lfsr[5] ? 6'h10 : (lfsr[4] ? 6'h20 : lfsr[5:0]))});
      bus_wdata = ~lfsr;
      bus_we    = lfsr[9] & lfsr[11];
      bus_re    = lfsr[10];
      @(negedge clk);
    end
    bus_we = 1'b0; bus_re = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule